// File: doc/BRIEF.md
# Display CRT Controller Register File

This block holds the vertical and addressing configuration of a character/graphics display controller. Software reaches it through two byte ports. A write to the index port selects a register. A write to the data port loads the selected register. A read of either port returns the index or the selected register. The stored bytes are decoded into configuration values that the rest of the display pipeline uses directly. These values are the wide vertical timing parameters, the split-screen line, the display and cursor start addresses, the cursor shape, the scan-line repeat count, the smooth-scroll skips and the memory address shift.

A small vertical line counter advances once for each `line_step_i` pulse. It returns to zero after it reaches the vertical total. It produces a split-screen wrap strobe on the line that matches the line compare value. It also sets a sticky vertical interrupt flag on the line that matches retrace start, unless that interrupt is masked. A write-lock bit protects the horizontal and vertical timing registers. The split-screen bit carried in the overflow register is still accepted while the lock is set.

Top module: `crtc_regfile`

## Requirements
- R1: `bus_rdata_o` returns the stored index when `bus_data_sel_i` is 0. When it is 1, it returns the register the index selects. Indices 0x00 to 0x18 are implemented. A data write to any higher index is ignored, and such an index reads as 0x00.
- R2: While bit 7 of register 0x11 is 1, data writes to indices 0x00 to 0x07 leave those registers unchanged. Writes to other indices still take effect.
- R3: Every data write to index 0x07 loads its bit 4 into bit 8 of the line compare value, including while the lock of R2 is set. The stored byte of register 0x07 still obeys R2.
- R4: Three values are assembled with bit 9, bit 8 and bits 7:0 in that order. `vtotal_o` is {r07[5], r07[0], r06}. `vdisp_end_o` is {r07[6], r07[1], r12}. `vret_start_o` is {r07[7], r07[2], r10}. `vblank_start_o` is {r07[3], r15}.
- R5: `line_cmp_o` is {r09[6], bit of R3, r18}.
- R6: `row_lines_o` is (r09[4:0] + 1). The result is doubled when r09[7] is 1.
- R7: `cursor_first_o` = r0A[4:0] and `cursor_on_o` = !r0A[5]. `cursor_last_o` = r0B[4:0] and `cursor_skew_o` = r0B[6:5].
- R8: `start_addr_o` = {r0C, r0D} and `cursor_addr_o` = {r0E, r0F}.
- R9: `addr_shift_o` is 2 when r14[6] is 1. Otherwise it is 0 when r17[6] is 1. Otherwise it is 1.
- R10: `skip_lines_o` = r08[4:0] and `skip_bytes_o` = r08[6:5].
- R11: On a clock with `line_step_i` high, `line_cnt_o` becomes 0 if it equalled `vtotal_o`. Otherwise it increments modulo 1024. Without a step, it holds.
- R12: `split_wrap_o` is high exactly when `line_step_i` is high and `line_cnt_o` equals `line_cmp_o`.
- R13: `vint_o` sets after a step taken while `line_cnt_o` equals `vret_start_o` and r11[5] is 0. It clears after a data write to 0x11 with bit 4 = 0. If both happen in one cycle, it sets. The r11[5] mask that applies is the value before that cycle's write.
- R14: After reset, all registers, the index, the line counter and `vint_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_data_sel_i | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected port |
| line_step_i | input | 1 | Advance the line counter by one line |
| vtotal_o | output | 10 | Vertical total |
| vdisp_end_o | output | 10 | Vertical display end |
| vret_start_o | output | 10 | Vertical retrace start |
| vblank_start_o | output | 9 | Vertical blank start |
| line_cmp_o | output | 10 | Split-screen line |
| start_addr_o | output | 16 | Display start address |
| cursor_addr_o | output | 16 | Cursor address |
| cursor_first_o | output | 5 | First cursor scan line |
| cursor_last_o | output | 5 | Last cursor scan line |
| cursor_skew_o | output | 2 | Cursor delay in character clocks |
| cursor_on_o | output | 1 | Cursor enabled |
| row_lines_o | output | 7 | Scan lines per row |
| skip_lines_o | output | 5 | Lines skipped at the top |
| skip_bytes_o | output | 2 | Bytes skipped at line start |
| addr_shift_o | output | 2 | Memory address shift: 0 byte, 1 word, 2 dword |
| line_cnt_o | output | 10 | Current line count |
| split_wrap_o | output | 1 | Split-screen address restart strobe |
| vint_o | output | 1 | Pending vertical interrupt |

## Verification
Two functions can act on the interrupt flag in the same cycle. One is a retrace hit from the line counter. The other is a data write to register 0x11 with bit 4 clear. The bench selects index 0x11 in advance and steps the counter until it sits on the retrace line. It then issues the clearing write and the step in the same clock, and requires `vint_o` to be set afterwards. A second collision is checked the same way: a locked write to the overflow register must change line compare bit 8 while leaving the vertical total and the register's readback untouched.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned IW       = 8;
  localparam int unsigned LW       = 10;
  localparam int unsigned NUM_REGS = 25;
  localparam int unsigned PROT_LIM = 8;

  localparam logic [IW-1:0] IDX_VTOT = 8'h06;
  localparam logic [IW-1:0] IDX_OVF  = 8'h07;
  localparam logic [IW-1:0] IDX_SKIP = 8'h08;
  localparam logic [IW-1:0] IDX_MSL  = 8'h09;
  localparam logic [IW-1:0] IDX_CSS  = 8'h0A;
  localparam logic [IW-1:0] IDX_CSE  = 8'h0B;
  localparam logic [IW-1:0] IDX_SAH  = 8'h0C;
  localparam logic [IW-1:0] IDX_SAL  = 8'h0D;
  localparam logic [IW-1:0] IDX_CAH  = 8'h0E;
  localparam logic [IW-1:0] IDX_CAL  = 8'h0F;
  localparam logic [IW-1:0] IDX_VRS  = 8'h10;
  localparam logic [IW-1:0] IDX_VRE  = 8'h11;
  localparam logic [IW-1:0] IDX_VDE  = 8'h12;
  localparam logic [IW-1:0] IDX_ULN  = 8'h14;
  localparam logic [IW-1:0] IDX_VBS  = 8'h15;
  localparam logic [IW-1:0] IDX_MOD  = 8'h17;
  localparam logic [IW-1:0] IDX_LCMP = 8'h18;

  typedef enum logic [1:0] {
    SHIFT_BYTE  = 2'd0,
    SHIFT_WORD  = 2'd1,
    SHIFT_DWORD = 2'd2
  } addr_shift_e;
endpackage

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
  import crtc_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         sel_data_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [IW-1:0]                idx_o,
  output logic [N_REGS-1:0][DW-1:0]    regs_o,
  output logic                         lc8_o,
  output logic [DW-1:0]                rdata_o
);
  logic [IW-1:0]             idx_q;
  logic [N_REGS-1:0][DW-1:0] regs_q;
  logic                      lc8_q;
  logic                      lock;
  logic                      dwr;

  assign lock = regs_q[IDX_VRE][7];
  assign dwr  = we_i & sel_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (we_i && !sel_data_i) idx_q <= wdata_i;
  end

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [IW-1:0] MY_IDX = IW'(g);
    localparam bit            PROT   = (g < PROT_LIM);
    logic wr_ok;
    if (PROT) begin : g_prot
      assign wr_ok = dwr && (idx_q == MY_IDX) && !lock;
    end else begin : g_open
      assign wr_ok = dwr && (idx_q == MY_IDX);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    regs_q[g] <= '0;
      else if (wr_ok) regs_q[g] <= wdata_i;
    end
  end

  // split-line bit 8 bypasses the lock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lc8_q <= 1'b0;
    else if (dwr && (idx_q == IDX_OVF))   lc8_q <= wdata_i[4];
  end

  always_comb begin
    logic [DW-1:0] sel;
    sel = '0;
    for (int i = 0; i < N_REGS; i++)
      if (idx_q == IW'(i)) sel = regs_q[i];
    rdata_o = sel_data_i ? sel : idx_q;
  end

  assign idx_o  = idx_q;
  assign regs_o = regs_q;
  assign lc8_o  = lc8_q;
endmodule

// File: rtl/crtc_decode.sv
module crtc_decode
  import crtc_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS
) (
  input  logic [N_REGS-1:0][DW-1:0] regs_i,
  input  logic                      lc8_i,
  output logic [LW-1:0]             vtotal_o,
  output logic [LW-1:0]             vdisp_end_o,
  output logic [LW-1:0]             vret_start_o,
  output logic [LW-2:0]             vblank_start_o,
  output logic [LW-1:0]             line_cmp_o,
  output logic [2*DW-1:0]           start_addr_o,
  output logic [2*DW-1:0]           cursor_addr_o,
  output logic [4:0]                cursor_first_o,
  output logic [4:0]                cursor_last_o,
  output logic [1:0]                cursor_skew_o,
  output logic                      cursor_on_o,
  output logic [6:0]                row_lines_o,
  output logic [4:0]                skip_lines_o,
  output logic [1:0]                skip_bytes_o,
  output logic [1:0]                addr_shift_o,
  output logic                      vint_en_o
);
  logic [DW-1:0] ovf, msl;
  logic [6:0]    row_base;
  addr_shift_e   shift;

  assign ovf = regs_i[IDX_OVF];
  assign msl = regs_i[IDX_MSL];

  assign vtotal_o       = {ovf[5], ovf[0], regs_i[IDX_VTOT]};
  assign vdisp_end_o    = {ovf[6], ovf[1], regs_i[IDX_VDE]};
  assign vret_start_o   = {ovf[7], ovf[2], regs_i[IDX_VRS]};
  assign vblank_start_o = {ovf[3], regs_i[IDX_VBS]};
  assign line_cmp_o     = {msl[6], lc8_i, regs_i[IDX_LCMP]};

  assign start_addr_o  = {regs_i[IDX_SAH], regs_i[IDX_SAL]};
  assign cursor_addr_o = {regs_i[IDX_CAH], regs_i[IDX_CAL]};

  assign cursor_first_o = regs_i[IDX_CSS][4:0];
  assign cursor_on_o    = ~regs_i[IDX_CSS][5];
  assign cursor_last_o  = regs_i[IDX_CSE][4:0];
  assign cursor_skew_o  = regs_i[IDX_CSE][6:5];

  assign row_base    = {2'b00, msl[4:0]} + 7'd1;
  assign row_lines_o = msl[7] ? {row_base[5:0], 1'b0} : row_base;

  assign skip_lines_o = regs_i[IDX_SKIP][4:0];
  assign skip_bytes_o = regs_i[IDX_SKIP][6:5];

  always_comb begin
    if (regs_i[IDX_ULN][6])      shift = SHIFT_DWORD;
    else if (regs_i[IDX_MOD][6]) shift = SHIFT_BYTE;
    else                         shift = SHIFT_WORD;
  end
  assign addr_shift_o = shift;

  assign vint_en_o = ~regs_i[IDX_VRE][5];
endmodule

// File: rtl/crtc_line_ctr.sv
module crtc_line_ctr
  import crtc_pkg::*;
#(
  parameter int unsigned CW = LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] vtotal_i,
  input  logic [CW-1:0] vret_i,
  input  logic [CW-1:0] lcmp_i,
  input  logic          vint_en_i,
  input  logic          vint_clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          vint_o
);
  logic [CW-1:0] cnt_q;
  logic          vint_q;
  logic          hit_ret;

  assign hit_ret = step_i && (cnt_q == vret_i) && vint_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q == vtotal_i) ? '0 : cnt_q + 1'b1;
  end

  // a retrace hit outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vint_q <= 1'b0;
    else if (hit_ret)    vint_q <= 1'b1;
    else if (vint_clr_i) vint_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign vint_o = vint_q;
  assign wrap_o = step_i && (cnt_q == lcmp_i);
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic          bus_data_sel_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          line_step_i,
  output logic [9:0]    vtotal_o,
  output logic [9:0]    vdisp_end_o,
  output logic [9:0]    vret_start_o,
  output logic [8:0]    vblank_start_o,
  output logic [9:0]    line_cmp_o,
  output logic [15:0]   start_addr_o,
  output logic [15:0]   cursor_addr_o,
  output logic [4:0]    cursor_first_o,
  output logic [4:0]    cursor_last_o,
  output logic [1:0]    cursor_skew_o,
  output logic          cursor_on_o,
  output logic [6:0]    row_lines_o,
  output logic [4:0]    skip_lines_o,
  output logic [1:0]    skip_bytes_o,
  output logic [1:0]    addr_shift_o,
  output logic [9:0]    line_cnt_o,
  output logic          split_wrap_o,
  output logic          vint_o
);
  logic [IW-1:0]             idx_q;
  logic [N_REGS-1:0][DW-1:0] regs;
  logic                      lc8;
  logic                      vint_en;
  logic                      vint_clr;

  crtc_reg_bank #(.N_REGS(N_REGS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .sel_data_i (bus_data_sel_i),
    .wdata_i    (bus_wdata_i),
    .idx_o      (idx_q),
    .regs_o     (regs),
    .lc8_o      (lc8),
    .rdata_o    (bus_rdata_o)
  );

  crtc_decode #(.N_REGS(N_REGS)) u_dec (
    .regs_i         (regs),
    .lc8_i          (lc8),
    .vtotal_o       (vtotal_o),
    .vdisp_end_o    (vdisp_end_o),
    .vret_start_o   (vret_start_o),
    .vblank_start_o (vblank_start_o),
    .line_cmp_o     (line_cmp_o),
    .start_addr_o   (start_addr_o),
    .cursor_addr_o  (cursor_addr_o),
    .cursor_first_o (cursor_first_o),
    .cursor_last_o  (cursor_last_o),
    .cursor_skew_o  (cursor_skew_o),
    .cursor_on_o    (cursor_on_o),
    .row_lines_o    (row_lines_o),
    .skip_lines_o   (skip_lines_o),
    .skip_bytes_o   (skip_bytes_o),
    .addr_shift_o   (addr_shift_o),
    .vint_en_o      (vint_en)
  );

  assign vint_clr = bus_we_i && bus_data_sel_i && (idx_q == IDX_VRE) && !bus_wdata_i[4];

  crtc_line_ctr #(.CW(LW)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (line_step_i),
    .vtotal_i   (vtotal_o),
    .vret_i     (vret_start_o),
    .lcmp_i     (line_cmp_o),
    .vint_en_i  (vint_en),
    .vint_clr_i (vint_clr),
    .cnt_o      (line_cnt_o),
    .wrap_o     (split_wrap_o),
    .vint_o     (vint_o)
  );
endmodule

// File: rtl/crtc_regfile_chk.sv
module crtc_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we,
  input logic       sel,
  input logic [7:0] wdata,
  input logic [7:0] idx,
  input logic       lock,
  input logic       step,
  input logic [9:0] cnt,
  input logic [9:0] vtotal,
  input logic [9:0] vret,
  input logic [9:0] lcmp,
  input logic       vint_en,
  input logic       vint,
  input logic [1:0] shift
);
  logic ret_hit;
  assign ret_hit = step && (cnt == vret) && vint_en;

  p_locked_vtot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && sel && idx == 8'h06 && lock) |=> $stable(vtotal[7:0]));

  p_ovf_lc8_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && sel && idx == 8'h07) |=> (lcmp[8] == $past(wdata[4])));

  p_cnt_inc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt != vtotal) |=> (cnt == $past(cnt) + 10'd1));

  p_cnt_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt == vtotal) |=> (cnt == 10'd0));

  p_cnt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(cnt));

  p_vint_set_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_hit |=> vint);

  p_vint_clr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && sel && idx == 8'h11 && !wdata[4] && !ret_hit) |=> !vint);

  always_comb begin
    if (rst_ni) p_shift_code_r9: assert (shift != 2'd3);
  end
endmodule

bind crtc_regfile crtc_regfile_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we      (bus_we_i),
  .sel     (bus_data_sel_i),
  .wdata   (bus_wdata_i),
  .idx     (idx_q),
  .lock    (regs[crtc_pkg::IDX_VRE][7]),
  .step    (line_step_i),
  .cnt     (line_cnt_o),
  .vtotal  (vtotal_o),
  .vret    (vret_start_o),
  .lcmp    (line_cmp_o),
  .vint_en (vint_en),
  .vint    (vint_o),
  .shift   (addr_shift_o)
);

// File: tb/crtc_regfile_test.sv
`timescale 1ns/1ps
module crtc_regfile_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0, sel = 1'b0, step = 1'b0;
  logic [7:0] wd = 8'h00;

  logic [7:0] rdata;
  logic [9:0] vtot, vde, vrs, lcmp, lcnt;
  logic [8:0] vbs;
  logic [15:0] saddr, caddr;
  logic [4:0] cfirst, clast, skl;
  logic [1:0] cskew, skb, shift;
  logic       con, wrap, vint;
  logic [6:0] rowl;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  crtc_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_data_sel_i(sel),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .line_step_i(step),
    .vtotal_o(vtot), .vdisp_end_o(vde), .vret_start_o(vrs), .vblank_start_o(vbs),
    .line_cmp_o(lcmp), .start_addr_o(saddr), .cursor_addr_o(caddr),
    .cursor_first_o(cfirst), .cursor_last_o(clast), .cursor_skew_o(cskew),
    .cursor_on_o(con), .row_lines_o(rowl), .skip_lines_o(skl), .skip_bytes_o(skb),
    .addr_shift_o(shift), .line_cnt_o(lcnt), .split_wrap_o(wrap), .vint_o(vint)
  );

  // behavioural reference state
  bit [7:0] m_reg [0:24];
  bit [7:0] m_idx;
  bit       m_lc8;
  int       m_cnt;
  bit       m_vint;

  function automatic int e_vtot();  return m_reg[6]  + 256*m_reg[7][0] + 512*m_reg[7][5]; endfunction
  function automatic int e_vde();   return m_reg[18] + 256*m_reg[7][1] + 512*m_reg[7][6]; endfunction
  function automatic int e_vrs();   return m_reg[16] + 256*m_reg[7][2] + 512*m_reg[7][7]; endfunction
  function automatic int e_vbs();   return m_reg[21] + 256*m_reg[7][3]; endfunction
  function automatic int e_lcmp();  return m_reg[24] + 256*m_lc8 + 512*m_reg[9][6]; endfunction
  function automatic int e_row();   return ((m_reg[9] & 31) + 1) * (m_reg[9][7] ? 2 : 1); endfunction
  function automatic int e_shift(); return m_reg[20][6] ? 2 : (m_reg[23][6] ? 0 : 1); endfunction
  function automatic int e_rdata();
    if (!sel) return m_idx;
    return (m_idx < 25) ? m_reg[m_idx] : 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_reg[i]) m_reg[i] = 8'h00;
      m_idx = 0; m_lc8 = 0; m_cnt = 0; m_vint = 0;
    end else begin
      bit set_v, clr_v;
      int vt;
      set_v = step && (m_cnt == e_vrs()) && !m_reg[17][5];
      clr_v = we && sel && (m_idx == 8'h11) && !wd[4];
      vt    = e_vtot();
      if (we && !sel) m_idx = wd;
      else if (we && sel) begin
        if (m_idx < 25 && !(m_reg[17][7] && m_idx < 8)) m_reg[m_idx] = wd;
        if (m_idx == 8'h07) m_lc8 = wd[4];
      end
      if (step) m_cnt = (m_cnt == vt) ? 0 : (m_cnt + 1) % 1024;
      if (set_v) m_vint = 1'b1;
      else if (clr_v) m_vint = 1'b0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst_ni) begin
      chk("R14", "rdata", rdata, 0);
      chk("R14", "line_cnt", lcnt, 0);
      chk("R14", "vint", vint, 0);
    end else begin
      chk("R1",  "rdata",     rdata,  e_rdata());
      chk("R4",  "vtotal",    vtot,   e_vtot());
      chk("R4",  "vdisp_end", vde,    e_vde());
      chk("R4",  "vret",      vrs,    e_vrs());
      chk("R4",  "vblank",    vbs,    e_vbs());
      chk("R5",  "line_cmp",  lcmp,   e_lcmp());
      chk("R8",  "start",     saddr,  m_reg[12]*256 + m_reg[13]);
      chk("R8",  "cursor",    caddr,  m_reg[14]*256 + m_reg[15]);
      chk("R7",  "cfirst",    cfirst, m_reg[10] & 31);
      chk("R7",  "con",       con,    !m_reg[10][5]);
      chk("R7",  "clast",     clast,  m_reg[11] & 31);
      chk("R7",  "cskew",     cskew,  (m_reg[11] >> 5) & 3);
      chk("R6",  "row",       rowl,   e_row());
      chk("R10", "skl",       skl,    m_reg[8] & 31);
      chk("R10", "skb",       skb,    (m_reg[8] >> 5) & 3);
      chk("R9",  "shift",     shift,  e_shift());
      chk("R11", "line_cnt",  lcnt,   m_cnt);
      chk("R12", "wrap",      wrap,   step && (m_cnt == e_lcmp()));
      chk("R13", "vint",      vint,   m_vint);
    end
  end

  task automatic cyc(bit w, bit s, bit [7:0] d, bit st);
    @(negedge clk); #1;
    we = w; sel = s; wd = d; step = st;
  endtask
  task automatic idle(); cyc(0, 0, 8'h00, 0); endtask
  task automatic wr(bit [7:0] i, bit [7:0] d);
    cyc(1, 0, i, 0); cyc(1, 1, d, 0); idle();
  endtask
  task automatic rd(bit [7:0] i, output int v);
    cyc(1, 0, i, 0); cyc(0, 1, 8'h00, 0); #0.5; v = rdata; idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL all watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    idle();
    #0.5 chk("R14", "index", rdata, 0);

    // R1: fill and read back all implemented registers
    for (int i = 0; i < 25; i++) wr(i[7:0], 8'((i*29 + 7) & 255));
    for (int i = 0; i < 25; i++) begin
      rd(i[7:0], v);
      chk("R1", "readback", v, m_reg[i]);
    end
    wr(8'h30, 8'hAA);
    rd(8'h30, v);       chk("R1", "unimpl", v, 0);
    #0.5 chk("R1", "index", rdata, 8'h30);
    wr(8'h19, 8'h5C);
    rd(8'h19, v);       chk("R1", "unimpl19", v, 0);

    // R2/R3: write lock and the split-line bypass
    wr(8'h11, 8'h00);
    wr(8'h06, 8'h12); wr(8'h07, 8'h00);
    wr(8'h11, 8'h80);
    wr(8'h06, 8'h55);
    rd(8'h06, v);       chk("R2", "locked r06", v, 8'h12);
    chk("R2", "vtotal held", vtot, 10'h012);
    wr(8'h07, 8'hFF);
    rd(8'h07, v);       chk("R2", "locked r07", v, 8'h00);
    chk("R3", "lc8 set", lcmp[8], 1);
    chk("R2", "vtotal held2", vtot, 10'h012);
    wr(8'h08, 8'h7F);
    rd(8'h08, v);       chk("R2", "open r08", v, 8'h7F);
    wr(8'h07, 8'h00);
    chk("R3", "lc8 clr", lcmp[8], 0);
    wr(8'h11, 8'h00);

    // R4/R5: overflow patterns
    wr(8'h07, 8'hA5);   chk("R4", "vtot a5", vtot, {1'b1, 1'b1, 8'h12});
    wr(8'h07, 8'h5A);   chk("R4", "vde 5a", vde, {1'b1, 1'b1, m_reg[18]});
    wr(8'h09, 8'h40);   chk("R5", "lcmp b9", lcmp, 512 + 256 + m_reg[24]);

    // R6: row lines
    wr(8'h09, 8'h9F);   chk("R6", "row x2", rowl, 64);
    wr(8'h09, 8'h07);   chk("R6", "row", rowl, 8);

    // R9: shift priority
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        wr(8'h14, a ? 8'h40 : 8'h00);
        wr(8'h17, b ? 8'h40 : 8'h00);
        chk("R9", "shift", shift, a ? 2 : (b ? 0 : 1));
      end

    // R11-R13: line counter, wrap and vertical interrupt
    wr(8'h06, 8'h05); wr(8'h07, 8'h00); wr(8'h09, 8'h00);
    wr(8'h10, 8'h03); wr(8'h18, 8'h02); wr(8'h11, 8'h00);
    for (int k = 0; k < 12; k++) cyc(0, 0, 8'h00, 1);
    idle();
    chk("R13", "vint set", vint, 1);
    cyc(1, 0, 8'h11, 0);
    cyc(1, 1, 8'h10, 0); idle();
    chk("R13", "bit4 set keeps", vint, 1);
    cyc(1, 1, 8'h00, 0); idle();
    chk("R13", "cleared", vint, 0);
    while (m_cnt != 3) begin cyc(0, 0, 8'h00, 1); idle(); end
    cyc(1, 1, 8'h00, 1); idle();
    chk("R13", "set beats clear", vint, 1);
    chk("R11", "after ret", lcnt, 4);
    cyc(1, 1, 8'h20, 0); idle();
    chk("R13", "masked clear", vint, 0);
    for (int k = 0; k < 12; k++) cyc(0, 0, 8'h00, 1);
    idle();
    chk("R13", "masked stays", vint, 0);
    repeat (4) idle();
    summary();
  end
endmodule